// File: doc/BRIEF.md
# Debounced Option Strap Reader

This block turns three configuration straps into registered operating options for a multi-channel touch sensing core. The straps are resistors on pins that also carry sensing signals, so they can only be read while the sensing logic releases those pins. A read takes a run of consecutive samples, one per sampling tick. The read is accepted only when every sample in the run carries the same pin pattern. A single disagreeing sample throws the read away, and the options already latched stay in force.

One strap selects slow/synchronised mode or fast/spread-spectrum mode. The other two straps together select one of four behaviours: a 10 s, 60 s or unlimited maximum detection time with level outputs, or toggle outputs with a 10 s limit. The first read starts straight out of reset. After that, the straps are read again every `REREAD_TICKS` sampling ticks. Once options are valid, a reread is held off while any channel reports a detection, and a detection that appears during a reread cancels it. `read_active` tells the surrounding logic when to release the shared pins.

Top module: `strap_reader`

## Requirements
- R1: After reset, `opt_valid`, `opt_slow` and `opt_toggle` are 0, `opt_hold` is 2'b00, and `read_active` is 1 because the power-up read begins at once.
- R2: A read is accepted after `SAMPLES` sampling ticks with identical pin patterns. The options are visible on the clock after the last of those tick edges, and `opt_valid` then stays 1 until reset.
- R3: If any sample differs from the first sample of the read, the read is abandoned on that tick edge and the previous options are kept. A fresh read starts on the next sampling tick.
- R4: `strap_pin[0]` high selects slow/sync mode (`opt_slow` = 1), and low selects fast mode (`opt_slow` = 0).
- R5: `{strap_pin[2], strap_pin[1]}` sets `opt_hold` as follows: 00 gives 2'b00 (unlimited), 01 gives 2'b10 (60 s), 10 gives 2'b01 (10 s), and 11 gives 2'b01 (10 s).
- R6: Code 11 on `{strap_pin[2], strap_pin[1]}` sets `opt_toggle` = 1. Every other code gives `opt_toggle` = 0.
- R7: A new read starts on the (`REREAD_TICKS`+1)-th sampling tick after the previous read was accepted, provided no detection blocks it.
- R8: While `opt_valid` is 1 and `any_detect` is 1, no read starts and the options do not change. The read starts on the first sampling tick after `any_detect` falls.
- R9: While `opt_valid` is 1, `any_detect` rising during a read ends that read on the next clock and leaves the options unchanged.
- R10: Before the first accepted read, `any_detect` has no effect on reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | One-cycle sampling enable (nominally every 10 µs) |
| strap_pin | input | 3 | [0] speed strap, [1] second option strap, [2] third option strap |
| any_detect | input | 1 | High while any sensing channel reports a detection |
| read_active | output | 1 | High while a read is in progress (shared pins released) |
| opt_valid | output | 1 | Options hold an accepted reading |
| opt_slow | output | 1 | 1 = slow/sync mode, 0 = fast mode |
| opt_hold | output | 2 | Maximum detection time: 00 unlimited, 01 10 s, 10 60 s |
| opt_toggle | output | 1 | Toggle output mode |

## Verification
Options change on the clock edge of the `SAMPLES`-th sampling tick of a read and can be seen at the following falling edge. The bench counts tick edges from the rise of `read_active` and expects exactly `SAMPLES`, and from acceptance to the next read it expects `REREAD_TICKS`+1. A mismatch or a detection removes `read_active` one edge later: on the tick edge for a mismatch, on the next clock for a detection. The bench drives its inputs on falling edges. It paces itself with a tick counter, so every check falls on the first falling edge after the edge where the result is due, and a scoreboard compares each option change against the queued expectation.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int STRAP_W = 3;

  typedef enum logic [1:0] {
    HOLD_INF = 2'b00,
    HOLD_10S = 2'b01,
    HOLD_60S = 2'b10
  } hold_e;

  typedef enum logic [1:0] {
    RD_SCAN = 2'b00,
    RD_WAIT = 2'b01,
    RD_PEND = 2'b10
  } rd_state_e;

  typedef struct packed {
    logic  slow;
    hold_e hold;
    logic  toggle;
  } opt_t;

  localparam opt_t OPT_IDLE = '{slow: 1'b0, hold: HOLD_INF, toggle: 1'b0};

  // pins[0] speed, pins[1] second option strap, pins[2] third option strap
  function automatic opt_t strap_decode(input logic [STRAP_W-1:0] pins);
    opt_t o;
    o.slow = pins[0];
    case (pins[2:1])
      2'b00:   begin o.hold = HOLD_INF; o.toggle = 1'b0; end
      2'b01:   begin o.hold = HOLD_60S; o.toggle = 1'b0; end
      2'b10:   begin o.hold = HOLD_10S; o.toggle = 1'b0; end
      default: begin o.hold = HOLD_10S; o.toggle = 1'b1; end
    endcase
    return o;
  endfunction

endpackage

// File: rtl/strap_sampler.sv
module strap_sampler #(
  parameter int SAMPLES = 25,
  parameter int W       = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_tick,
  input  logic         scan_en,
  input  logic [W-1:0] pins,
  output logic         smp_done,
  output logic         smp_abort,
  output logic [W-1:0] smp_word
);
  localparam int CW = $clog2(SAMPLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  ref_q;
  logic [W-1:0]  agree;
  logic          first_smp;
  logic          all_agree;
  logic          take;

  // per-pin agreement with the first sample of the run
  for (genvar g = 0; g < W; g++) begin : g_cmp
    assign agree[g] = ~(pins[g] ^ ref_q[g]);
  end

  assign first_smp = (cnt_q == '0);
  assign all_agree = &agree;
  assign take      = scan_en & sample_tick;
  assign smp_abort = take & ~first_smp & ~all_agree;
  assign smp_done  = take & ~first_smp & all_agree & (cnt_q == LAST);
  assign smp_word  = ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ref_q <= '0;
    end else if (!scan_en) begin
      cnt_q <= '0;
    end else if (sample_tick) begin
      if (first_smp) begin
        ref_q <= pins;
        cnt_q <= CW'(1);
      end else if (smp_abort || smp_done) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/strap_sched.sv
module strap_sched
  import strap_pkg::*;
#(
  parameter int REREAD_TICKS = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic any_detect,
  input  logic opts_valid,
  input  logic smp_done,
  input  logic smp_abort,
  output logic scan_en
);
  localparam int IW = $clog2(REREAD_TICKS + 1);
  localparam logic [IW-1:0] ILAST = IW'(REREAD_TICKS - 1);

  rd_state_e     st_q;
  logic [IW-1:0] icnt_q;
  logic          blocked;
  logic          interval_up;

  // detection gates reads only once a valid setting exists
  assign blocked     = any_detect & opts_valid;
  assign interval_up = sample_tick & (icnt_q == ILAST);
  assign scan_en     = (st_q == RD_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_SCAN;
      icnt_q <= '0;
    end else begin
      case (st_q)
        RD_SCAN: begin
          if (smp_done) begin
            st_q   <= RD_WAIT;
            icnt_q <= '0;
          end else if (smp_abort || blocked) begin
            st_q <= RD_PEND;
          end
        end
        RD_WAIT: begin
          if (interval_up)      st_q   <= RD_PEND;
          else if (sample_tick) icnt_q <= icnt_q + IW'(1);
        end
        RD_PEND: begin
          if (sample_tick && !blocked) st_q <= RD_SCAN;
        end
        default: st_q <= RD_PEND;
      endcase
    end
  end

endmodule

// File: rtl/strap_optreg.sv
module strap_optreg
  import strap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [STRAP_W-1:0] word,
  output opt_t               opt_q,
  output logic               valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q   <= OPT_IDLE;
      valid_q <= 1'b0;
    end else if (load) begin
      opt_q   <= strap_decode(word);
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/strap_reader.sv
module strap_reader
  import strap_pkg::*;
#(
  parameter int SAMPLES      = 25,
  parameter int REREAD_TICKS = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic [2:0] strap_pin,
  input  logic       any_detect,
  output logic       read_active,
  output logic       opt_valid,
  output logic       opt_slow,
  output logic [1:0] opt_hold,
  output logic       opt_toggle
);
  logic               smp_done_w;
  logic               smp_abort_w;
  logic               scan_en_w;
  logic [STRAP_W-1:0] smp_word_w;
  opt_t               opt_w;
  logic               valid_w;

  strap_sampler #(.SAMPLES(SAMPLES), .W(STRAP_W)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_tick(sample_tick),
    .scan_en    (scan_en_w),
    .pins       (strap_pin),
    .smp_done   (smp_done_w),
    .smp_abort  (smp_abort_w),
    .smp_word   (smp_word_w)
  );

  strap_sched #(.REREAD_TICKS(REREAD_TICKS)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_tick(sample_tick),
    .any_detect (any_detect),
    .opts_valid (valid_w),
    .smp_done   (smp_done_w),
    .smp_abort  (smp_abort_w),
    .scan_en    (scan_en_w)
  );

  strap_optreg u_optreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (smp_done_w),
    .word   (smp_word_w),
    .opt_q  (opt_w),
    .valid_q(valid_w)
  );

  assign read_active = scan_en_w;
  assign opt_valid   = valid_w;
  assign opt_slow    = opt_w.slow;
  assign opt_hold    = opt_w.hold;
  assign opt_toggle  = opt_w.toggle;

endmodule

// File: rtl/strap_reader_chk.sv
module strap_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       any_detect,
  input logic       read_active,
  input logic       opt_valid,
  input logic       opt_slow,
  input logic [1:0] opt_hold,
  input logic       opt_toggle,
  input logic       smp_done,
  input logic       smp_abort
);
  assert_quiet_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_valid |-> (!opt_slow && opt_hold == 2'b00 && !opt_toggle));

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    opt_valid |=> opt_valid);

  assert_change_on_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_done |=> $stable({opt_valid, opt_slow, opt_hold, opt_toggle}));

  assert_abort_ends_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_abort |=> !read_active);

  assert_hold_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    opt_hold != 2'b11);

  assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    opt_toggle |-> opt_hold == 2'b01);

  assert_no_start_on_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_valid && any_detect && !read_active) |=> !read_active);

  assert_detect_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_valid && any_detect && read_active) |=> !read_active);
endmodule

bind strap_reader strap_reader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .any_detect (any_detect),
  .read_active(read_active),
  .opt_valid  (opt_valid),
  .opt_slow   (opt_slow),
  .opt_hold   (opt_hold),
  .opt_toggle (opt_toggle),
  .smp_done   (smp_done_w),
  .smp_abort  (smp_abort_w)
);

// File: tb/test_strap_reader.sv
`timescale 1ns/1ps
module test_strap_reader;
  localparam int SAMPLES = 25;
  localparam int REREAD  = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] pins = 3'b011;
  logic       detect = 1'b1;
  logic       read_active, opt_valid, opt_slow, opt_toggle;
  logic [1:0] opt_hold;
  int         tests = 0;
  int         fails = 0;
  int         tdiv = 0;

  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic [4:0] last_o = 5'b0;
  wire  [4:0] cur_o = {opt_valid, opt_slow, opt_hold, opt_toggle};

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == 4) ? 0 : tdiv + 1;
    tick <= (tdiv == 4);
  end

  strap_reader #(.SAMPLES(SAMPLES), .REREAD_TICKS(REREAD)) i_strap_reader (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .strap_pin(pins),
    .any_detect(detect), .read_active(read_active), .opt_valid(opt_valid),
    .opt_slow(opt_slow), .opt_hold(opt_hold), .opt_toggle(opt_toggle)
  );

  // {valid, slow, hold, toggle} from the requirement tables
  function automatic logic [4:0] expect_of(input logic [2:0] p);
    logic [1:0] h;
    logic       t;
    t = 1'b0;
    if (!p[2] && !p[1])     h = 2'b00;
    else if (!p[2] && p[1]) h = 2'b10;
    else if (p[2] && !p[1]) h = 2'b01;
    else begin h = 2'b01; t = 1'b1; end
    return {1'b1, p[0], h, t};
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every output change must match the queued item
  always @(negedge clk) begin
    if (!rst_n) last_o = cur_o;
    else if (cur_o !== last_o) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R3 unexpected option change actual=%b expected=%b", cur_o, last_o);
      end else begin
        logic [4:0] e;
        string      tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check_eq(tg, int'(cur_o), int'(e));
      end
      last_o = cur_o;
    end
  end

  task automatic push_exp(input logic [2:0] p, input string tag);
    exp_q.push_back(expect_of(p));
    tag_q.push_back(tag);
  endtask

  task automatic wait_drained(input string tag);
    int t = 0;
    while (exp_q.size() != 0 && t < 3000) begin @(negedge clk); t++; end
    check_eq(tag, exp_q.size(), 0);
  endtask

  // returns after the n-th following tick edge, at a falling edge
  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!tick) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wait_read_start();
    int t = 0;
    while (!read_active && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic run_code(input logic [2:0] p, input string tag);
    logic [4:0] snap;
    int n = 0;
    pins = p;
    push_exp(p, tag);
    wait_read_start();
    snap = cur_o;
    while (n < 200) begin
      @(negedge clk);
      if (tick) begin
        @(negedge clk);
        n++;
        if (cur_o !== snap) break;
      end
    end
    check_eq("R2 ticks per accepted read", n, SAMPLES);
    wait_drained(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1 valid after reset", opt_valid, 0);
    check_eq("R1 options after reset", {opt_slow, opt_hold, opt_toggle}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 power-up read active", read_active, 1);
    // R10: detect held high during the power-up read
    push_exp(3'b011, "R10 power-up read ignores detect");
    wait_drained("R10 drained");
    detect = 1'b0;

    // R7: reread interval
    begin
      int n = 0;
      while (!read_active && n < 500) begin
        @(negedge clk);
        if (tick) begin @(negedge clk); n++; end
      end
      check_eq("R7 ticks to reread", n, REREAD + 1);
    end
    wait_ticks(SAMPLES);

    // R4 R5 R6: all four option codes, both speeds
    run_code(3'b000, "R5 code 00 fast unlimited");
    run_code(3'b110, "R6 code 11 toggle");
    run_code(3'b101, "R4 R5 code 10 slow 10s");
    run_code(3'b011, "R5 code 01 slow 60s");

    // R3: single-sample glitch
    pins = 3'b000;
    wait_read_start();
    wait_ticks(1);
    pins = 3'b011;
    wait_ticks(1);
    check_eq("R3 read abandoned", read_active, 0);
    check_eq("R3 options kept", int'(cur_o), int'(expect_of(3'b011)));
    pins = 3'b000;
    wait_ticks(1);
    check_eq("R3 read retried", read_active, 1);
    push_exp(3'b000, "R3 retry accepted");
    wait_drained("R3 drained");

    // R8: detection defers the reread
    detect = 1'b1;
    pins = 3'b110;
    begin
      int bad = 0;
      repeat ((REREAD + 20) * 5) begin
        @(negedge clk);
        if (read_active) bad++;
      end
      check_eq("R8 no read while detecting", bad, 0);
    end
    check_eq("R8 options unchanged", int'(cur_o), int'(expect_of(3'b000)));
    detect = 1'b0;
    wait_ticks(1);
    check_eq("R8 read starts after release", read_active, 1);
    push_exp(3'b110, "R8 deferred read accepted");
    wait_drained("R8 drained");

    // R9: detection during a read cancels it
    pins = 3'b101;
    wait_read_start();
    wait_ticks(3);
    detect = 1'b1;
    @(negedge clk);
    check_eq("R9 read cancelled", read_active, 0);
    check_eq("R9 options unchanged", int'(cur_o), int'(expect_of(3'b110)));
    detect = 1'b0;
    push_exp(3'b101, "R9 later read accepted");
    wait_drained("R9 drained");

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule